// File: doc/BRIEF.md
# Flash Reset and Abort Sequencer

This block watches the active-low reset pin of a flash-style memory and turns it into the qualifiers that the rest of the device relies on. These are an internal reset level, a request that forces the command decoder back to array-read mode, a one-cycle abort strobe for the program/erase engine, read-allowed and write-allowed flags, and the drive enable of the data bus.

There are two cases. In the first, reset falls while no program or erase is running. The pin must then stay low for a minimum number of cycles before the device enters reset, and shorter glitches are ignored. In the second, reset falls while an operation is busy. The operation is aborted at once, and a fixed shutdown interval follows. Once that interval is over, the block either begins recovery or, if the pin is still low, stays in reset until the pin is released.

Recovery always begins with a one-cycle load of the status value 80H. Reads are then allowed after a read-recovery count, and writes after a separate write-recovery count. A bus access attempted while it is not allowed is blocked and raises a one-cycle violation flag.

Top module: `flash_rst_seq`

## Requirements
- R1: After the synchronous block reset, int_rst, force_rdarray, op_abort, stat_load and both violation flags are 0, and rd_ok and wr_ok are 1.
- R2: The reset pin passes through a two-flop chain. A pin level driven during cycle c is acted on by the sequencer at the clock edge that ends cycle c+2, so its outputs change three edges after the pin.
- R3: While idle, a pin held low for at least MIN_PULSE cycles puts the block in reset. With the pin driven low in cycle c0, int_rst and force_rdarray rise in cycle c0+2+MIN_PULSE. While int_rst is high, rd_ok, wr_ok and data_oe are 0.
- R4: While idle, a low pulse shorter than MIN_PULSE cycles has no effect. int_rst stays 0, rd_ok and wr_ok stay 1, and no strobe fires.
- R5: Recovery starts in the cycle in which int_rst and force_rdarray fall. In that same cycle stat_load pulses for exactly one cycle, with stat_value equal to 8'h80.
- R6: Counting the first recovery cycle as 0, rd_ok rises in recovery cycle RD_REC and wr_ok rises in recovery cycle WR_REC.
- R7: If the pin falls while op_busy is 1, op_abort pulses for exactly one cycle, together with the rise of int_rst. This happens regardless of how long the pin stays low.
- R8: An abort keeps int_rst high for SHUT_CYC cycles. If the pin has been released by then, recovery starts right at the end of that interval, not at the release.
- R9: If the pin is still low when the shutdown interval ends, int_rst stays high. Recovery then starts three edges after the pin is released.
- R10: A read with rd_ok at 0 is blocked: data_oe stays 0, and rd_viol pulses in the next cycle. A write with wr_ok at 0 pulses wr_viol in the next cycle. An allowed read drives data_oe, and allowed accesses raise no flag.
- R11: A pin low seen during recovery returns the block to reset at once, with no minimum pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high block reset |
| pin_rst_n | input | 1 | Asynchronous active-low device reset pin |
| op_busy | input | 1 | A program or erase is in progress |
| bus_rd | input | 1 | Bus read attempt in this cycle |
| bus_wr | input | 1 | Bus write attempt in this cycle |
| data_oe | output | 1 | Data bus drive enable |
| int_rst | output | 1 | Internal reset level |
| force_rdarray | output | 1 | Forces the command decoder to array-read mode |
| op_abort | output | 1 | One-cycle abort strobe to the operation engine |
| stat_load | output | 1 | One-cycle load of the status register |
| stat_value | output | 8 | Value loaded into the status register |
| rd_ok | output | 1 | Reads are allowed |
| wr_ok | output | 1 | Writes are allowed |
| rd_viol | output | 1 | A blocked read occurred in the previous cycle |
| wr_viol | output | 1 | A blocked write occurred in the previous cycle |

## Verification
A sequencer stuck in the wrong state shows up at the ports as an int_rst edge, an op_abort or stat_load strobe, or an rd_ok/wr_ok rise in the wrong cycle. Each of these is fixed to an exact cycle offset from the pin edges, so it is caught within at most SHUT_CYC plus WR_REC cycles of the stimulus. A miscount in the pulse filter appears as a reset entered one cycle early or late, or as a short glitch that is wrongly obeyed. A blocked or wrongly allowed access appears the next cycle as a missing or spurious violation flag, or as a data_oe value that does not match.

// File: rtl/frs_pkg.sv
package frs_pkg;

    typedef enum logic [2:0] {
        ST_RUN,
        ST_PEND,
        ST_RESET,
        ST_ABORT,
        ST_RECOVER
    } frs_state_e;

    typedef struct packed {
        logic int_rst;
        logic force_rdarray;
        logic abort;
        logic stat_load;
        logic rd_ok;
        logic wr_ok;
    } frs_qual_t;

    localparam logic [7:0] FRS_STAT_INIT = 8'h80;

    function automatic int frs_max(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    function automatic int frs_width(input int v);
        int w;
        w = $clog2(v + 1);
        return (w < 1) ? 1 : w;
    endfunction

endpackage

// File: rtl/frs_sync.sv
module frs_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pin_n,
    output logic pin_low
);
    logic [STAGES-1:0] chain;

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[g] <= 1'b1;
                    else     chain[g] <= pin_n;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain[g] <= 1'b1;
                    else     chain[g] <= chain[g-1];
                end
            end
        end
    endgenerate

    assign pin_low = ~chain[STAGES-1];

    // R2: first stage samples the pin every cycle outside reset
    assert_sync_sample_R2: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (chain[0] == $past(pin_n)));

endmodule

// File: rtl/frs_ctrl.sv
module frs_ctrl
    import frs_pkg::*;
#(
    parameter int MIN_PULSE = 3,
    parameter int SHUT_CYC  = 5,
    parameter int RD_REC    = 4,
    parameter int WR_REC    = 6
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      pin_low,
    input  logic      op_busy,
    output frs_qual_t qual
);
    localparam int REC_MAX = frs_max(RD_REC, WR_REC);
    localparam int CNT_TOP = frs_max(frs_max(MIN_PULSE, SHUT_CYC), REC_MAX);
    localparam int CNT_W   = frs_width(CNT_TOP);

    localparam logic [CNT_W-1:0] PULSE_LAST = CNT_W'(frs_max(MIN_PULSE - 1, 0));
    localparam logic [CNT_W-1:0] SHUT_LAST  = CNT_W'(frs_max(SHUT_CYC - 1, 0));
    localparam logic [CNT_W-1:0] REC_LAST   = CNT_W'(REC_MAX);
    localparam logic [CNT_W-1:0] RD_LIM     = CNT_W'(RD_REC);
    localparam logic [CNT_W-1:0] WR_LIM     = CNT_W'(WR_REC);
    localparam logic [CNT_W-1:0] CNT_ONE    = CNT_W'(1);

    frs_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        case (state_q)
            ST_RUN: begin
                if (pin_low) begin
                    if (op_busy) begin
                        state_d = ST_ABORT;
                        cnt_d   = '0;
                    end else if (MIN_PULSE < 2) begin
                        state_d = ST_RESET;
                        cnt_d   = '0;
                    end else begin
                        state_d = ST_PEND;
                        cnt_d   = CNT_ONE;
                    end
                end
            end
            ST_PEND: begin
                if (!pin_low) begin
                    state_d = ST_RUN;
                    cnt_d   = '0;
                end else if (cnt_q >= PULSE_LAST) begin
                    state_d = ST_RESET;
                    cnt_d   = '0;
                end else begin
                    cnt_d = cnt_q + CNT_ONE;
                end
            end
            ST_RESET: begin
                if (!pin_low) begin
                    state_d = ST_RECOVER;
                    cnt_d   = '0;
                end
            end
            ST_ABORT: begin
                if (cnt_q == SHUT_LAST) begin
                    state_d = pin_low ? ST_RESET : ST_RECOVER;
                    cnt_d   = '0;
                end else begin
                    cnt_d = cnt_q + CNT_ONE;
                end
            end
            ST_RECOVER: begin
                if (pin_low) begin
                    state_d = ST_RESET;
                    cnt_d   = '0;
                end else if (cnt_q == REC_LAST) begin
                    state_d = ST_RUN;
                    cnt_d   = '0;
                end else begin
                    cnt_d = cnt_q + CNT_ONE;
                end
            end
            default: begin
                state_d = ST_RESET;
                cnt_d   = '0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_RUN;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    logic in_reset, in_run, in_rec;
    assign in_reset = (state_q == ST_RESET) || (state_q == ST_ABORT);
    assign in_run   = (state_q == ST_RUN) || (state_q == ST_PEND);
    assign in_rec   = (state_q == ST_RECOVER);

    always_comb begin
        qual.int_rst       = in_reset;
        qual.force_rdarray = in_reset;
        qual.abort         = (state_q == ST_ABORT) && (cnt_q == '0);
        qual.stat_load     = in_rec && (cnt_q == '0);
        qual.rd_ok         = in_run || (in_rec && (cnt_q >= RD_LIM));
        qual.wr_ok         = in_run || (in_rec && (cnt_q >= WR_LIM));
    end

    // R7: abort strobe lasts one cycle and follows a busy operation
    assert_abort_single_R7: assert property (@(posedge clk) disable iff (rst)
        qual.abort |=> !qual.abort);
    assert_abort_busy_R7: assert property (@(posedge clk) disable iff (rst)
        qual.abort |-> $past(op_busy));
    // R3: no access qualifier while in reset
    assert_reset_blocks_R3: assert property (@(posedge clk) disable iff (rst)
        qual.int_rst |-> (!qual.rd_ok && !qual.wr_ok));
    // R5: status load is a single pulse
    assert_stat_single_R5: assert property (@(posedge clk) disable iff (rst)
        qual.stat_load |=> !qual.stat_load);
    // R8: shutdown interval ends after SHUT_CYC cycles
    assert_shutdown_end_R8: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_ABORT && cnt_q == SHUT_LAST) |=> (state_q != ST_ABORT));
    // R4: a pending low pulse keeps both accesses allowed
    assert_pending_open_R4: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_PEND) |-> (qual.rd_ok && qual.wr_ok && !qual.int_rst));

endmodule

// File: rtl/frs_gate.sv
module frs_gate (
    input  logic clk,
    input  logic rst,
    input  logic rd_ok,
    input  logic wr_ok,
    input  logic bus_rd,
    input  logic bus_wr,
    output logic data_oe,
    output logic rd_viol,
    output logic wr_viol
);
    logic rd_viol_q, wr_viol_q;

    assign data_oe = bus_rd & rd_ok;

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_viol_q <= 1'b0;
            wr_viol_q <= 1'b0;
        end else begin
            rd_viol_q <= bus_rd & ~rd_ok;
            wr_viol_q <= bus_wr & ~wr_ok;
        end
    end

    assign rd_viol = rd_viol_q;
    assign wr_viol = wr_viol_q;

    // R10: flags trace back to a blocked access one cycle earlier
    assert_rd_flag_R10: assert property (@(posedge clk) disable iff (rst)
        rd_viol |-> ($past(bus_rd) && !$past(rd_ok)));
    assert_wr_flag_R10: assert property (@(posedge clk) disable iff (rst)
        wr_viol |-> ($past(bus_wr) && !$past(wr_ok)));
    assert_no_drive_R10: assert property (@(posedge clk) disable iff (rst)
        !rd_ok |-> !data_oe);

endmodule

// File: rtl/flash_rst_seq.sv
module flash_rst_seq
    import frs_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int MIN_PULSE   = 3,
    parameter int SHUT_CYC    = 5,
    parameter int RD_REC      = 4,
    parameter int WR_REC      = 6
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       pin_rst_n,
    input  logic       op_busy,
    input  logic       bus_rd,
    input  logic       bus_wr,
    output logic       data_oe,
    output logic       int_rst,
    output logic       force_rdarray,
    output logic       op_abort,
    output logic       stat_load,
    output logic [7:0] stat_value,
    output logic       rd_ok,
    output logic       wr_ok,
    output logic       rd_viol,
    output logic       wr_viol
);
    logic      pin_low;
    frs_qual_t qual;

    frs_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk     (clk),
        .rst     (rst),
        .pin_n   (pin_rst_n),
        .pin_low (pin_low)
    );

    frs_ctrl #(
        .MIN_PULSE (MIN_PULSE),
        .SHUT_CYC  (SHUT_CYC),
        .RD_REC    (RD_REC),
        .WR_REC    (WR_REC)
    ) ctrl_i (
        .clk     (clk),
        .rst     (rst),
        .pin_low (pin_low),
        .op_busy (op_busy),
        .qual    (qual)
    );

    frs_gate gate_i (
        .clk     (clk),
        .rst     (rst),
        .rd_ok   (qual.rd_ok),
        .wr_ok   (qual.wr_ok),
        .bus_rd  (bus_rd),
        .bus_wr  (bus_wr),
        .data_oe (data_oe),
        .rd_viol (rd_viol),
        .wr_viol (wr_viol)
    );

    assign int_rst       = qual.int_rst;
    assign force_rdarray = qual.force_rdarray;
    assign op_abort      = qual.abort;
    assign stat_load     = qual.stat_load;
    assign stat_value    = FRS_STAT_INIT;
    assign rd_ok         = qual.rd_ok;
    assign wr_ok         = qual.wr_ok;

endmodule

// File: tb/flash_rst_seq_tb_top.sv
`timescale 1ns/1ps
module flash_rst_seq_tb_top;
    localparam int MIN_P = 3;
    localparam int SHUT  = 5;
    localparam int RD    = 4;
    localparam int WR    = 6;

    localparam int K_RST_ON  = 0;
    localparam int K_ABORT   = 1;
    localparam int K_RST_OFF = 2;
    localparam int K_STAT    = 3;
    localparam int K_RD_OK   = 4;
    localparam int K_WR_OK   = 5;
    localparam int K_RD_VIOL = 6;
    localparam int K_WR_VIOL = 7;

    logic clk = 1'b0;
    logic rst, pin_rst_n, op_busy, bus_rd, bus_wr;
    logic data_oe, int_rst, force_rdarray, op_abort, stat_load, rd_ok, wr_ok, rd_viol, wr_viol;
    logic [7:0] stat_value;

    always #2.5 clk = ~clk;

    flash_rst_seq #(
        .SYNC_STAGES (2),
        .MIN_PULSE   (MIN_P),
        .SHUT_CYC    (SHUT),
        .RD_REC      (RD),
        .WR_REC      (WR)
    ) dut_i (
        .clk (clk), .rst (rst), .pin_rst_n (pin_rst_n), .op_busy (op_busy),
        .bus_rd (bus_rd), .bus_wr (bus_wr), .data_oe (data_oe), .int_rst (int_rst),
        .force_rdarray (force_rdarray), .op_abort (op_abort), .stat_load (stat_load),
        .stat_value (stat_value), .rd_ok (rd_ok), .wr_ok (wr_ok),
        .rd_viol (rd_viol), .wr_viol (wr_viol)
    );

    int n_cmp = 0;
    int n_bad = 0;
    int cyc = 0;
    bit mon_on = 1'b0;
    bit done = 1'b0;

    int    exp_k[$];
    int    exp_c[$];
    string exp_t[$];

    always @(posedge clk) cyc <= cyc + 1;

    task automatic push(input int k, input int c, input string tag);
        exp_k.push_back(k);
        exp_c.push_back(c);
        exp_t.push_back(tag);
    endtask

    task automatic chk(input logic act, input logic expv, input string tag, input string what);
        n_cmp++;
        if (act !== expv) begin
            n_bad++;
            $display("FAIL %s %s at cycle %0d: actual %0b expected %0b", tag, what, cyc, act, expv);
        end
    endtask

    function automatic void see(input int k);
        int    ek, ec;
        string et;
        n_cmp++;
        if (exp_k.size() == 0) begin
            n_bad++;
            $display("FAIL unexpected event at cycle %0d: actual kind %0d expected none", cyc, k);
        end else begin
            ek = exp_k.pop_front();
            ec = exp_c.pop_front();
            et = exp_t.pop_front();
            if (ek != k || ec != cyc) begin
                n_bad++;
                $display("FAIL %s event: actual kind %0d cycle %0d expected kind %0d cycle %0d",
                         et, k, cyc, ek, ec);
            end
        end
    endfunction

    // Monitor: turns port activity into events, compared in a fixed per-cycle order
    logic p_rst, p_rd, p_wr;
    always @(negedge clk) begin
        if (mon_on && !done) begin
            if (int_rst && !p_rst)  see(K_RST_ON);
            if (op_abort)           see(K_ABORT);
            if (!int_rst && p_rst)  see(K_RST_OFF);
            if (stat_load) begin
                see(K_STAT);
                n_cmp++;
                if (stat_value !== 8'h80) begin
                    n_bad++;
                    $display("FAIL R5 stat_value: actual %h expected 80", stat_value);
                end
            end
            if (rd_ok && !p_rd)     see(K_RD_OK);
            if (wr_ok && !p_wr)     see(K_WR_OK);
            if (rd_viol)            see(K_RD_VIOL);
            if (wr_viol)            see(K_WR_VIOL);
        end
        p_rst = int_rst;
        p_rd  = rd_ok;
        p_wr  = wr_ok;
    end

    task automatic step();
        @(negedge clk);
    endtask

    // Idle reset of P cycles (R3, R5, R6), or a filtered glitch when P < MIN_P (R4)
    task automatic idle_reset(input int P);
        int c0, rel;
        step();
        c0 = cyc;
        rel = c0 + P + 3;
        pin_rst_n = 1'b0;
        if (P >= MIN_P) begin
            push(K_RST_ON,  c0 + 2 + MIN_P, "R3");
            push(K_RST_OFF, rel, "R5");
            push(K_STAT,    rel, "R5");
            push(K_RD_OK,   rel + RD, "R6");
            push(K_WR_OK,   rel + WR, "R6");
        end
        for (int i = 1; i <= P + WR + 8; i++) begin
            step();
            if (cyc == c0 + P) begin
                if (P >= MIN_P + 2) begin
                    chk(force_rdarray, 1'b1, "R3", "force_rdarray in reset");
                    chk(wr_ok, 1'b0, "R3", "wr_ok in reset");
                end
                pin_rst_n = 1'b1;
            end
            if (P >= MIN_P && cyc == rel) chk(force_rdarray, 1'b0, "R5", "force_rdarray at release");
            if (P < MIN_P && cyc == c0 + P + 3) begin
                chk(rd_ok, 1'b1, "R4", "rd_ok after glitch");
                chk(int_rst, 1'b0, "R4", "int_rst after glitch");
            end
        end
    endtask

    // Reset pulse of P cycles while an operation runs (R2, R7, R8, R9)
    task automatic abort_reset(input int P);
        int c0, rel;
        string tg;
        step();
        c0 = cyc;
        op_busy = 1'b1;
        pin_rst_n = 1'b0;
        rel = (P <= SHUT) ? c0 + 3 + SHUT : c0 + P + 3;
        tg  = (P <= SHUT) ? "R8" : "R9";
        push(K_RST_ON,  c0 + 3, "R2");
        push(K_ABORT,   c0 + 3, "R7");
        push(K_RST_OFF, rel, tg);
        push(K_STAT,    rel, tg);
        push(K_RD_OK,   rel + RD, tg);
        push(K_WR_OK,   rel + WR, tg);
        for (int i = 1; i <= P + SHUT + WR + 8; i++) begin
            step();
            if (cyc == c0 + P) pin_rst_n = 1'b1;
            if (cyc == c0 + 3) op_busy = 1'b0;
            if (cyc == rel - 1) chk(int_rst, 1'b1, tg, "int_rst before recovery");
        end
    endtask

    // Blocked and allowed accesses around a reset (R10)
    task automatic access_test();
        int c0, rel;
        step();
        c0 = cyc;
        rel = c0 + MIN_P + 5;
        pin_rst_n = 1'b0;
        push(K_RST_ON,  c0 + MIN_P + 2, "R3");
        push(K_RD_VIOL, c0 + MIN_P + 4, "R10");
        push(K_RST_OFF, rel, "R5");
        push(K_STAT,    rel, "R5");
        push(K_RD_OK,   rel + RD, "R6");
        push(K_WR_VIOL, rel + RD + 1, "R10");
        push(K_WR_OK,   rel + WR, "R6");
        for (int i = 1; i <= MIN_P + WR + 12; i++) begin
            step();
            bus_rd = 1'b0;
            bus_wr = 1'b0;
            if (cyc == c0 + MIN_P + 2) pin_rst_n = 1'b1;
            if (cyc == c0 + MIN_P + 3) begin
                bus_rd = 1'b1;
                #0.1;
                chk(data_oe, 1'b0, "R10", "data_oe on blocked read");
            end
            if (cyc == rel + RD) begin
                bus_rd = 1'b1;
                bus_wr = 1'b1;
                #0.1;
                chk(data_oe, 1'b1, "R10", "data_oe on allowed read");
            end
        end
    endtask

    // Pin low again during recovery (R11)
    task automatic reentry_test();
        int c0, rel, c2;
        step();
        c0 = cyc;
        rel = c0 + MIN_P + 4;
        c2  = c0 + MIN_P + 6;
        pin_rst_n = 1'b0;
        push(K_RST_ON,  c0 + MIN_P + 2, "R3");
        push(K_RST_OFF, rel, "R5");
        push(K_STAT,    rel, "R5");
        push(K_RST_ON,  rel + 2, "R11");
        push(K_RST_OFF, c2 + 3, "R11");
        push(K_STAT,    c2 + 3, "R11");
        push(K_RD_OK,   c2 + 3 + RD, "R11");
        push(K_WR_OK,   c2 + 3 + WR, "R11");
        for (int i = 1; i <= MIN_P + WR + 16; i++) begin
            step();
            if (cyc == c0 + MIN_P + 1) pin_rst_n = 1'b1;
            if (cyc == c0 + MIN_P + 3) pin_rst_n = 1'b0;
            if (cyc == c2) pin_rst_n = 1'b1;
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            while (exp_k.size() > 0) begin
                n_cmp++;
                n_bad++;
                $display("FAIL %s missing event: actual none expected kind %0d cycle %0d",
                         exp_t[0], exp_k[0], exp_c[0]);
                void'(exp_k.pop_front());
                void'(exp_c.pop_front());
                void'(exp_t.pop_front());
            end
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        rst = 1'b1; pin_rst_n = 1'b1; op_busy = 1'b0; bus_rd = 1'b0; bus_wr = 1'b0;
        repeat (4) @(posedge clk);
        step();
        rst = 1'b0;
        step();
        p_rst = int_rst; p_rd = rd_ok; p_wr = wr_ok;
        mon_on = 1'b1;

        chk(int_rst, 1'b0, "R1", "int_rst after reset");
        chk(force_rdarray, 1'b0, "R1", "force_rdarray after reset");
        chk(op_abort, 1'b0, "R1", "op_abort after reset");
        chk(stat_load, 1'b0, "R1", "stat_load after reset");
        chk(rd_ok, 1'b1, "R1", "rd_ok after reset");
        chk(wr_ok, 1'b1, "R1", "wr_ok after reset");
        chk(rd_viol | wr_viol, 1'b0, "R1", "violation flags after reset");

        bus_rd = 1'b1; bus_wr = 1'b1;
        #0.1;
        chk(data_oe, 1'b1, "R10", "data_oe on read while running");
        step();
        bus_rd = 1'b0; bus_wr = 1'b0;
        repeat (3) step();

        idle_reset(MIN_P + 3);
        idle_reset(MIN_P);
        idle_reset(MIN_P - 1);
        idle_reset(1);
        abort_reset(2);
        abort_reset(SHUT);
        abort_reset(SHUT + 1);
        abort_reset(SHUT + 6);
        access_test();
        reentry_test();
        repeat (10) step();
        finish_run();
    end

endmodule